// File: doc/BRIEF.md
# Word-Parallel CRC-16 Engine

This block computes a 16-bit cyclic redundancy check with generator polynomial x^16 + x^12 + x^5 + 1 over packets that arrive as 32-bit words. It folds a whole word into the remainder in a single clock cycle. The combinational next-state network is the unrolled form of 32 single-bit shift steps, so a core clock that runs faster than the data source never needs to stall it.

A packet opens with a start strobe, which loads the remainder with all ones. Each word carries a valid strobe, and valid may drop for any number of cycles between words. The final word is also flagged as last. One cycle after that word is absorbed, a done pulse appears and the CRC output holds the finished checksum. Packets may be of any word count, and a new packet may start in the cycle right after the previous one ends.

Top module: `crc16_word`

## Requirements
- R1: While reset is held and just after it is released, `crc_o` reads 0xFFFF and `done_o` reads 0.
- R2: A start strobe with valid low makes `crc_o` read 0xFFFF after the next clock edge.
- R3: A valid word replaces the remainder with the result of 32 serial steps, taken from data bit 31 down to bit 0. In each step the feedback bit is remainder bit 15 XOR the data bit, the remainder shifts left by one, and it is XORed with 0x1021 when the feedback bit is 1.
- R4: A start strobe in the same cycle as a valid word absorbs that word starting from 0xFFFF and discards the old remainder.
- R5: In a cycle with neither valid nor start, `crc_o` keeps its value.
- R6: `done_o` is high for the single cycle that follows each clock edge at which a valid word flagged last is absorbed. In that cycle `crc_o` holds the checksum of the whole packet.
- R7: The last flag without valid does not raise `done_o` and does not change `crc_o`.
- R8: Packets of any length are handled, including one-word packets, packets of 16384 words with sparse valid, and packets that follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Start of packet; loads the remainder with all ones |
| vld_i | input | 1 | Data word valid this cycle |
| last_i | input | 1 | Marks the valid word as the final word of the packet |
| data_i | input | 32 | Data word, consumed MSB first |
| crc_o | output | 16 | Running remainder; the final checksum when done is high |
| done_o | output | 1 | One-cycle pulse after the last word is absorbed |

## Verification
The bench targets a start strobe that coincides with the first word. A design that applied the preload after the word, or ignored the word, would show a remainder that differs from the serial reference. It also runs idle gaps and a last flag with valid low. A design that advanced the remainder on idle cycles, or pulsed done on an invalid last word, would be caught there. A 16384-word packet with sparse valid and back-to-back one-word packets expose a done pulse that stretches, merges or goes missing, and any wrong bit order or wrong feedback tap in the unrolled network.

// File: rtl/crc16_word.sv
module crc16_word #(
  parameter int                DATA_W = 32,
  parameter int                CRC_W  = 16,
  parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] nxt;
  logic             done_q;

  assign seed = sop_i ? INIT : crc_q;

  always_comb begin
    logic fb;
    nxt = seed;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = nxt[CRC_W-1] ^ data_i[i];
      nxt = {nxt[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= INIT;
      done_q <= 1'b0;
    end else begin
      done_q <= vld_i & last_i;
      if (vld_i)      crc_q <= nxt;
      else if (sop_i) crc_q <= INIT;
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;

  // R2
  sop_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i && !vld_i |=> crc_o == INIT);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sop_i && !vld_i |=> $stable(crc_o));

  // R7
  no_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !done_o);

  // R6
  no_done_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && !last_i |=> !done_o);

endmodule

// File: tb/crc16_word_tb.sv
module crc16_word_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop_i = 1'b0, vld_i = 1'b0, last_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [15:0] crc_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] ref_crc = 16'hFFFF;
  logic        ref_done = 1'b0;

  always #2 clk = ~clk;

  crc16_word u_dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .vld_i(vld_i),
    .last_i(last_i), .data_i(data_i), .crc_o(crc_o), .done_o(done_o)
  );

  function automatic logic [15:0] serial_ref(input logic [15:0] r, input logic [31:0] d);
    logic [15:0] x = r;
    for (int b = 31; b >= 0; b--) begin
      if (x[15] != d[b]) x = (x << 1) ^ 16'h1021;
      else               x = x << 1;
    end
    return x;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (crc_o !== ref_crc || done_o !== ref_done) begin
      fails++;
      $display("FAIL %s crc=%h exp=%h done=%b exp=%b", tag, crc_o, ref_crc, done_o, ref_done);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic l, input logic [31:0] d,
                      input string tag, input bit do_chk);
    sop_i = s; vld_i = v; last_i = l; data_i = d;
    @(posedge clk);
    @(negedge clk);
    if (v)      ref_crc = serial_ref(s ? 16'hFFFF : ref_crc, d);
    else if (s) ref_crc = 16'hFFFF;
    ref_done = v & l;
    if (do_chk) check(tag);
  endtask

  // {sop, vld, last, data}
  localparam logic [34:0] VEC [14] = '{
    {3'b100, 32'h0000_0000},
    {3'b010, 32'h1234_5678},
    {3'b000, 32'hFFFF_FFFF},
    {3'b010, 32'h8000_0001},
    {3'b010, 32'h0000_0000},
    {3'b011, 32'hDEAD_BEEF},
    {3'b000, 32'h0000_0000},
    {3'b110, 32'hFFFF_FFFF},
    {3'b010, 32'hA5A5_5A5A},
    {3'b001, 32'h1111_1111},
    {3'b010, 32'h0F0F_F0F0},
    {3'b011, 32'h0000_0001},
    {3'b111, 32'hCAFE_F00D},
    {3'b000, 32'h0000_0000}
  };

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (crc_o !== 16'hFFFF || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset crc=%h exp=ffff done=%b exp=0", crc_o, done_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    ref_crc = 16'hFFFF; ref_done = 1'b0;
    check("R1 after release");

    for (int i = 0; i < 14; i++)
      step(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0], "R3 table step", 1'b1);

    // R2 preload without a word
    step(1'b0, 1'b1, 1'b0, 32'h7777_0000, "R3 dirty", 1'b1);
    step(1'b1, 1'b0, 1'b0, 32'h0, "R2 preload", 1'b1);
    // R4 start together with a word, after dirtying the remainder
    step(1'b0, 1'b1, 1'b0, 32'h1357_9BDF, "R3 dirty", 1'b1);
    step(1'b1, 1'b1, 1'b0, 32'h2468_ACE0, "R4 sop with word", 1'b1);
    // R5 idle hold over several cycles
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, 32'hFFFF_0000 + k, "R5 idle hold", 1'b1);
    // R7 last flag without valid
    step(1'b0, 1'b0, 1'b1, 32'hABCD_EF01, "R7 last no valid", 1'b1);
    step(1'b0, 1'b0, 1'b0, 32'h0, "R7 after", 1'b1);
    // R6 done pulse then drops
    step(1'b0, 1'b1, 1'b1, 32'h0BAD_CAFE, "R6 final word", 1'b1);
    step(1'b0, 1'b0, 1'b0, 32'h0, "R6 pulse drops", 1'b1);
    // R8 back-to-back one-word packets
    for (int k = 0; k < 5; k++)
      step(1'b1, 1'b1, 1'b1, 32'h0101_0101 * (k + 1), "R8 one-word packets", 1'b1);
    step(1'b0, 1'b0, 1'b0, 32'h0, "R8 after one-word", 1'b1);
    // R8 long packet with sparse valid
    step(1'b1, 1'b0, 1'b0, 32'h0, "R8 long open", 1'b1);
    begin
      int w = 0;
      int c = 0;
      while (w < 16384) begin
        logic [31:0] d = (w * 32'h9E37_79B9) ^ (w << 7);
        if (c % 3 == 2) begin
          step(1'b0, 1'b0, 1'b0, d, "R8 long gap", 1'b0);
        end else begin
          step(1'b0, 1'b1, w == 16383, d, "R8 long word", (w % 1024 == 0) || (w == 16383));
          w++;
        end
        c++;
      end
    end
    step(1'b0, 1'b0, 1'b0, 32'h0, "R8 long end", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule